// File: doc/BRIEF.md
# Three-Byte Write Receiver for a Two-Wire Serial Bus

This block is a write-only I2C slave. It runs on the system clock and oversamples the SCL and SDA lines. It answers two addresses: the device address on the `dev_addr` input and a fixed broadcast address, 7'h73. After it has acknowledged its address it takes exactly three data bytes and acknowledges each of them. It then hands the 24-bit word to the logic behind it as a single-cycle strobe. It refuses any byte that follows the third. The only thing the block drives on the bus is a pulldown enable for an open-drain SDA pad.

The state machine has seven states:
- `S_IDLE` waits for a START.
- `S_ADDR` shifts in the address byte.
- `S_ADDR_ACK` holds SDA low for the address acknowledge.
- `S_DATA` shifts in a data byte.
- `S_DATA_ACK` holds SDA low for a data acknowledge.
- `S_SKIP` leaves SDA released during the ninth clock of a surplus byte.
- `S_IGNORE` stays silent until the next START.

The transitions are as follows:
- A START goes from any state to `S_ADDR`, and a STOP goes from any state to `S_IDLE`.
- From `S_ADDR`, the SCL fall after the eighth bit goes to `S_ADDR_ACK` on a write to a matching address, and to `S_IGNORE` otherwise.
- `S_ADDR_ACK`, `S_DATA_ACK` and `S_SKIP` each return to `S_DATA` on the next SCL fall.
- From `S_DATA`, the SCL fall after the eighth bit goes to `S_DATA_ACK` for the first three bytes and to `S_SKIP` for every byte after them.

Top module: `i2c_word_slave`

## Requirements
- R1: While reset is held and directly after it is released, `sda_pull` is 0 and `word_valid` is 0.
- R2: An address byte whose upper seven bits equal `dev_addr` and whose bit 0 (the direction bit) is 0 is acknowledged: `sda_pull` is 1 while SCL is high on the ninth clock.
- R3: An address byte with the upper seven bits 7'h73 and bit 0 equal to 0 is acknowledged for every value of `dev_addr`.
- R4: An address byte that matches neither address, or that has bit 0 set, is not acknowledged. No later byte of that transaction is acknowledged and no strobe is produced before the next START.
- R5: Bits are taken on rising SCL with the MSB first. Each of the first three data bytes after an acknowledged address is acknowledged on its ninth clock.
- R6: After the third data byte, `word_valid` is 1 for exactly one clock. `word_data` then carries the first byte in bits 23:16, the second byte in bits 15:8 and the third byte in bits 7:0.
- R7: Every data byte after the third in the same transaction is not acknowledged and produces no further strobe.
- R8: A STOP, or a repeated START, before the third byte drops the partial word without a strobe. A repeated START begins a new address phase.
- R9: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| dev_addr | input | 7 | Device address to answer |
| sda_pull | output | 1 | 1 drives the SDA pad low |
| word_valid | output | 1 | One-cycle strobe marking a complete 24-bit word |
| word_data | output | 24 | Word received, first byte in the top bits |

## Verification
The hardest cases to reach are the ones where the transaction is cut short or runs long. These are a repeated START that arrives after two data bytes, and a fourth or fifth byte sent after the word has already been strobed. From the ports alone, both look like ordinary acknowledges and bytes. The bench therefore models a wired-AND bus and drives full transactions through it. It sweeps all 128 addresses for two device addresses, then sends five-byte transactions, STOPs in mid-word and repeated STARTs in mid-word. After each case it compares the acknowledge pattern, the number of strobes and the last word against values it computes itself.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;
    localparam logic [6:0] BCAST_ADDR = 7'h73;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA,
        S_DATA_ACK,
        S_SKIP,
        S_IGNORE
    } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= raw_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign start_det = scl_s && scl_d && sda_d && !sda_s;
    assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
    assign scl_rise  = scl_s && !scl_d;
    assign scl_fall  = !scl_s && scl_d;
endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave #(
    parameter int NUM_BYTES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic [6:0]             dev_addr,
    output logic                   sda_pull,
    output logic                   word_valid,
    output logic [8*NUM_BYTES-1:0] word_data
);
    import i2c_word_pkg::*;

    localparam int WORD_W = 8 * NUM_BYTES;
    localparam int BC_W   = $clog2(NUM_BYTES + 1);
    localparam logic [BC_W-1:0] BYTE_LIMIT = BC_W'(NUM_BYTES);
    localparam logic [BC_W-1:0] LAST_IDX   = BC_W'(NUM_BYTES - 1);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       start_det, stop_det, scl_rise, scl_fall;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({scl_in, sda_in}),
        .sync_out (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_cond_det u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    rx_state_t         state;
    logic [3:0]        bit_cnt;
    logic [BC_W-1:0]   byte_cnt;
    logic [7:0]        addr_sh;
    logic [WORD_W-1:0] word_sh;
    logic              addr_hit;
    logic              byte_done;

    assign addr_hit  = !addr_sh[0] &&
                       ((addr_sh[7:1] == dev_addr) || (addr_sh[7:1] == BCAST_ADDR));
    assign byte_done = scl_fall && (bit_cnt == 4'd8);

    // State register, bit and byte counting, word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            bit_cnt    <= '0;
            byte_cnt   <= '0;
            addr_sh    <= '0;
            word_sh    <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (start_det) begin
                state    <= S_ADDR;
                bit_cnt  <= '0;
                byte_cnt <= '0;
            end else if (stop_det) begin
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_IDLE, S_IGNORE: ;
                    S_ADDR: begin
                        if (scl_rise) begin
                            addr_sh <= {addr_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            state <= addr_hit ? S_ADDR_ACK : S_IGNORE;
                        end
                    end
                    S_DATA: begin
                        if (scl_rise) begin
                            word_sh <= {word_sh[WORD_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            if (byte_cnt < BYTE_LIMIT) begin
                                state    <= S_DATA_ACK;
                                byte_cnt <= byte_cnt + 1'b1;
                                if (byte_cnt == LAST_IDX) begin
                                    word_valid <= 1'b1;
                                    word_data  <= word_sh;
                                end
                            end else begin
                                state <= S_SKIP;
                            end
                        end
                    end
                    S_ADDR_ACK, S_DATA_ACK, S_SKIP: begin
                        if (scl_fall) begin
                            state   <= S_DATA;
                            bit_cnt <= '0;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            S_ADDR_ACK, S_DATA_ACK: sda_pull = 1'b1;
            default:                sda_pull = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_word_slave_chk.sv
module i2c_word_slave_chk
    import i2c_word_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sda_pull,
    input logic      word_valid,
    input logic      scl_s,
    input logic      start_det,
    input logic      stop_det,
    input rx_state_t state
);
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s)); // R9

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R6

    AST_STROBE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> sda_pull); // R5

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR) && !sda_pull); // R8

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == S_IDLE) && !word_valid); // R8

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_IGNORE && !$past(start_det)) |-> !word_valid && !sda_pull); // R4
endmodule

bind i2c_word_slave i2c_word_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull   (sda_pull),
    .word_valid (word_valid),
    .scl_s      (scl_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .state      (state)
);

// File: tb/tb_i2c_word_slave.sv
module tb_i2c_word_slave;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [6:0]  dev_addr = 7'h11;
    logic        sda_pull, word_valid;
    logic [23:0] word_data;
    wire         sda_line = m_sda & ~sda_pull;

    int          checks = 0;
    int          errors = 0;
    int          strobes = 0;
    int          r9_viol = 0;
    logic [23:0] last_word = '0;
    logic        prev_pull = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    i2c_word_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .dev_addr   (dev_addr),
        .sda_pull   (sda_pull),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    always @(negedge clk) begin
        if (word_valid) begin
            strobes++;
            last_word = word_data;
        end
        if (rst_n && sda_pull != prev_pull && m_scl) r9_viol++;
        prev_pull = sda_pull;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hwait();
        repeat (H) @(posedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hwait();
        m_scl = 1'b1; hwait();
        m_sda = 1'b0; hwait();
        m_scl = 1'b0; repeat (2) @(posedge clk);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hwait();
        m_scl = 1'b1; hwait();
        m_sda = 1'b1; hwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hwait();
            m_scl = 1'b1; hwait();
            m_scl = 1'b0; repeat (2) @(posedge clk);
        end
        m_sda = 1'b1; hwait();
        m_scl = 1'b1;
        repeat (H/2) @(posedge clk);
        @(negedge clk) ack = !sda_line;
        repeat (H/2) @(posedge clk);
        m_scl = 1'b0; repeat (2) @(posedge clk);
    endtask

    // Address byte plus n data bytes, acks packed: bit0 = address
    task automatic xfer(input logic [7:0] abyte, input logic [39:0] data, input int n,
                        input bit do_stop, output logic [5:0] acks);
        bit a;
        acks = '0;
        bus_start();
        send_byte(abyte, a); acks[0] = a;
        for (int k = 0; k < n; k++) begin
            send_byte(data[39-8*k -: 8], a);
            acks[k+1] = a;
        end
        if (do_stop) bus_stop();
        repeat (6) @(posedge clk);
    endtask

    initial begin
        logic [5:0] acks;
        int s0;
        logic [7:0] b0, b1, b2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sda_pull == 0 && word_valid == 0, "R1", {sda_pull, word_valid}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sda_pull == 0 && word_valid == 0, "R1", {sda_pull, word_valid}, 0);

        // Address sweep for two device addresses
        for (int d = 0; d < 2; d++) begin
            dev_addr = (d == 0) ? 7'h11 : 7'h5A;
            for (int a = 0; a < 128; a++) begin
                bit exp;
                exp = (7'(a) == dev_addr) || (a == 'h73);
                xfer({7'(a), 1'b0}, '0, 0, 1'b1, acks);
                if (a == 'h73) chk(acks[0] == exp, "R3", acks[0], exp);
                else if (exp) chk(acks[0] == exp, "R2", acks[0], exp);
                else chk(acks[0] == exp, "R4", acks[0], exp);
            end
        end
        dev_addr = 7'h11;

        // Read direction: neither own nor broadcast acked, no data acked
        s0 = strobes;
        xfer({7'h11, 1'b1}, 40'hA5_5A_C3_00_00, 3, 1'b1, acks);
        chk(acks[3:0] == 0, "R4", acks, 0);
        xfer({7'h73, 1'b1}, 40'h01_02_03_00_00, 3, 1'b1, acks);
        chk(acks[3:0] == 0 && strobes == s0, "R4", {acks, 8'(strobes - s0)}, 0);
        // Mismatching address followed by data
        xfer({7'h22, 1'b0}, 40'hFF_00_FF_00_00, 3, 1'b1, acks);
        chk(acks[3:0] == 0 && strobes == s0, "R4", {acks, 8'(strobes - s0)}, 0);

        // Several word patterns, own and broadcast address
        for (int p = 0; p < 6; p++) begin
            b0 = 8'(p * 37 + 1); b1 = 8'(8'hF0 ^ (p * 19)); b2 = 8'(p * 91 + 8'h80);
            s0 = strobes;
            xfer({(p % 2) ? 7'h73 : 7'h11, 1'b0}, {b0, b1, b2, 16'h0}, 3, 1'b1, acks);
            chk(acks[3:0] == 4'hF, "R5", acks, 4'hF);
            chk(strobes == s0 + 1, "R6", strobes - s0, 1);
            chk(last_word == {b0, b1, b2}, "R6", last_word, {b0, b1, b2});
        end

        // Surplus bytes
        s0 = strobes;
        xfer({7'h11, 1'b0}, 40'h12_34_56_78_9A, 5, 1'b1, acks);
        chk(acks[3:0] == 4'hF, "R5", acks, 4'hF);
        chk(acks[5:4] == 2'b00, "R7", acks[5:4], 0);
        chk(strobes == s0 + 1 && last_word == 24'h123456, "R7", last_word, 24'h123456);

        // STOP after one data byte, then a fresh word
        s0 = strobes;
        xfer({7'h11, 1'b0}, 40'hEE_00_00_00_00, 1, 1'b1, acks);
        chk(strobes == s0, "R8", strobes - s0, 0);
        xfer({7'h11, 1'b0}, 40'hC0_FF_EE_00_00, 3, 1'b1, acks);
        chk(strobes == s0 + 1 && last_word == 24'hC0FFEE, "R8", last_word, 24'hC0FFEE);

        // Repeated START after two data bytes
        s0 = strobes;
        xfer({7'h11, 1'b0}, 40'hAA_BB_00_00_00, 2, 1'b0, acks);
        chk(strobes == s0, "R8", strobes - s0, 0);
        xfer({7'h73, 1'b0}, 40'h0D_EC_AF_00_00, 3, 1'b1, acks);
        chk(acks[3:0] == 4'hF, "R8", acks, 4'hF);
        chk(strobes == s0 + 1 && last_word == 24'h0DECAF, "R8", last_word, 24'h0DECAF);

        chk(r9_viol == 0, "R9", r9_viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule